// File: doc/BRIEF.md
# Windowed-Timeout Watchdog Reset Generator

This block watches for loss of software control. It counts a slow tick. If software does not strobe the service input before the count reaches the selected timeout, the block pulls an active-low reset request low for a fixed number of system clocks. It also raises a status flag that stays set through the reset it caused, so boot code can tell this reset apart from the others. The running count has no output, so software cannot read it.

The tick comes from one of two sources. The first is an internal divider that turns the system clock into one tick every `DIV` clocks. The second is an external oscillator tick that has already been synchronized into the clock domain as a one-cycle strobe. A 2-bit select input either turns the watchdog off or picks one of three power-of-two timeouts.

The control is a three-state machine:

- `ST_OFF`: idle, with the counter held at zero. `ST_OFF -> ST_RUN` happens when the select becomes non-zero.
- `ST_RUN`: counting. `ST_RUN -> ST_OFF` happens when the select returns to zero. `ST_RUN -> ST_PULSE` happens on a timeout.
- `ST_PULSE`: the reset request is driven low. `ST_PULSE -> ST_RUN` happens after `PULSE` clocks when the select is non-zero. `ST_PULSE -> ST_OFF` happens after `PULSE` clocks when the select is zero.

Top module: `wdg_rstgen`

## Requirements
- R1: After power-on reset (`rst_n` low), `rst_req_n` is high, `wdg_flag` is low and the state is `ST_OFF`.
- R2: When `src_sel`=0, one tick occurs every `DIV` (default 128) clocks from a free-running divider. When `src_sel`=1, each clock in which `osc_tick` is high is one tick. In the clock where `src_sel` differs from its previous value, no tick is counted and the divider restarts from zero.
- R3: Select code `tmo_sel`=2'b00 disables the watchdog. The counter is held at zero and no reset request is made. Codes 2'b01, 2'b10 and 2'b11 select timeouts of 2^`LOG_A`, 2^`LOG_B` and 2^`LOG_C` ticks (defaults 2^12, 2^14 and 2^16).
- R4: A high `svc_wr` while running restarts the count from zero. If a service strobe and the timeout tick arrive in the same clock, the service wins.
- R5: When a tick brings the count to the selected timeout with no service strobe, `rst_req_n` is low from the following clock. This also applies when a shorter timeout is selected and the count is already at or above it; the next tick then times out.
- R6: `rst_req_n` stays low for exactly `PULSE` (default 16) clocks and then rises. Counting then restarts from zero. `svc_wr` has no effect while the pulse is active.
- R7: `wdg_flag` is set in the same clock that `rst_req_n` falls. It stays set until `flag_clr` or `rst_n` clears it. If a set and a clear occur in the same clock, the set wins.
- R8: Returning `tmo_sel` to 2'b00 while running stops the count. A later non-zero select starts a full timeout from zero, with one clock of `ST_OFF -> ST_RUN` latency before ticks count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| src_sel | input | 1 | Tick source: 0 = internal divider, 1 = external oscillator tick |
| osc_tick | input | 1 | Synchronized one-clock oscillator strobe |
| tmo_sel | input | 2 | 00 off, 01/10/11 = short/medium/long timeout |
| svc_wr | input | 1 | Service-register write strobe (data ignored) |
| flag_clr | input | 1 | Clears the sticky watchdog-reset flag |
| rst_req_n | output | 1 | Active-low chip reset request |
| wdg_flag | output | 1 | Sticky flag: a watchdog reset has occurred |

## Verification
The assertions assume four things about the inputs:

- `osc_tick` and `svc_wr` are single-clock synchronous strobes.
- `src_sel` and `tmo_sel` are synchronous levels.
- `DIV` is at least 2, so that two consecutive divider ticks cannot occur.
- `LOG_C` is the largest exponent.

The stimulus keeps within these assumptions. It drives every input only at the falling clock edge and holds each value for a whole cycle. It changes the source and the select only rarely and at random, and places service strobes both inside and outside the timeout window. The directed cases cover the same-clock service/timeout collision, the divider restart on a source change, and a disable in the middle of a count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } wdg_state_t;

    localparam logic [1:0] SEL_OFF = 2'b00;

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic osc_tick,
    output logic tick_o
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    logic          src_q;
    logic          swap;

    assign swap = (src_sel != src_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            src_q <= 1'b0;
        end else begin
            src_q <= src_sel;
            if (swap || src_sel || div_q == DIV_LAST)
                div_q <= '0;
            else
                div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = !swap && (src_sel ? osc_tick : (div_q == DIV_LAST));

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !src_sel) |=> !tick_o); // R2

endmodule

// File: rtl/wdg_cnt.sv
module wdg_cnt #(
    parameter int LOG_A = 12,
    parameter int LOG_B = 14,
    parameter int LOG_C = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       svc_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       tmo_o
);
    localparam int CW = LOG_C;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        unique case (sel_i)
            2'b01:   lim_m1 = {CW{1'b1}} >> (CW - LOG_A);
            2'b10:   lim_m1 = {CW{1'b1}} >> (CW - LOG_B);
            default: lim_m1 = {CW{1'b1}};
        endcase
    end

    assign tmo_o = en_i && !svc_i && tick_i && (cnt_q >= lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i || svc_i || tmo_o)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_SVC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && svc_i) |=> (cnt_q == '0)); // R4

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !svc_i && !tmo_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/wdg_rstgen.sv
module wdg_rstgen
    import wdg_pkg::*;
#(
    parameter int DIV   = 128,
    parameter int LOG_A = 12,
    parameter int LOG_B = 14,
    parameter int LOG_C = 16,
    parameter int PULSE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_sel,
    input  logic       osc_tick,
    input  logic [1:0] tmo_sel,
    input  logic       svc_wr,
    input  logic       flag_clr,
    output logic       rst_req_n,
    output logic       wdg_flag
);
    localparam int PW = $clog2(PULSE + 1);
    localparam logic [PW-1:0] PLS_LAST = PW'(PULSE - 1);

    wdg_state_t    state_q, state_d;
    logic [PW-1:0] pls_q;
    logic          tick;
    logic          run_en;
    logic          tmo;

    wdg_tick_gen #(.DIV(DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .osc_tick (osc_tick),
        .tick_o   (tick)
    );

    assign run_en = (state_q == ST_RUN) && (tmo_sel != SEL_OFF);

    wdg_cnt #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run_en),
        .svc_i  (svc_wr),
        .tick_i (tick),
        .sel_i  (tmo_sel),
        .tmo_o  (tmo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (tmo_sel != SEL_OFF) state_d = ST_RUN;
            ST_RUN: begin
                if (tmo_sel == SEL_OFF) state_d = ST_OFF;
                else if (tmo)           state_d = ST_PULSE;
            end
            ST_PULSE: if (pls_q == PLS_LAST)
                          state_d = (tmo_sel == SEL_OFF) ? ST_OFF : ST_RUN;
            default:  state_d = ST_OFF;
        endcase
    end

    // pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pls_q <= '0;
        else if (state_q != ST_PULSE) pls_q <= '0;
        else                         pls_q <= pls_q + 1'b1;
    end

    // sticky status flag: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       wdg_flag <= 1'b0;
        else if (state_d == ST_PULSE && state_q == ST_RUN) wdg_flag <= 1'b1;
        else if (flag_clr)                wdg_flag <= 1'b0;
    end

    // outputs
    always_comb begin
        rst_req_n = (state_q != ST_PULSE);
    end

    // checker: consecutive low cycles of the reset request
    logic [PW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_run <= '0;
        else if (!rst_req_n) low_run <= low_run + 1'b1;
        else                low_run <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_n) |-> (low_run == (PW+1)'(PULSE))); // R6

    AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |-> wdg_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_flag && !flag_clr) |=> wdg_flag); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmo_sel == SEL_OFF) && rst_req_n) |=> rst_req_n); // R3

endmodule

// File: tb/sim_wdg_rstgen.sv
`timescale 1ns/1ps
module sim_wdg_rstgen;
    localparam int DIV = 128;
    localparam int LA = 5, LB = 7, LC = 9;
    localparam int PULSE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b0, osc_tick = 1'b0, svc_wr = 1'b0, flag_clr = 1'b0;
    logic [1:0] tmo_sel = 2'b00;
    logic rst_req_n, wdg_flag;

    always #10 clk = ~clk;

    wdg_rstgen #(.DIV(DIV), .LOG_A(LA), .LOG_B(LB), .LOG_C(LC), .PULSE(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .osc_tick(osc_tick),
        .tmo_sel(tmo_sel), .svc_wr(svc_wr), .flag_clr(flag_clr),
        .rst_req_n(rst_req_n), .wdg_flag(wdg_flag)
    );

    int nvec = 0, nerr = 0;
    // expected-behaviour model (mode: 0 off, 1 running, 2 pulse)
    int m_mode, m_cnt, m_div, m_pls;
    bit m_selq, m_flag;

    function automatic int limit_of(bit [1:0] sl);
        return (sl == 2'b01) ? (1 << LA) : (sl == 2'b10) ? (1 << LB) : (1 << LC);
    endfunction

    function automatic bit tick_of(bit s, bit o, bit selq, int dv);
        if (s != selq) return 1'b0;
        return s ? o : (dv == DIV - 1);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(bit s, bit o, bit [1:0] sl, bit sv, bit cl);
        bit tk, to;
        tk = tick_of(s, o, m_selq, m_div);
        to = (m_mode == 1) && (sl != 0) && !sv && tk && (m_cnt >= limit_of(sl) - 1);
        m_div  = (s != m_selq || s || m_div == DIV - 1) ? 0 : m_div + 1;
        m_selq = s;
        m_flag = to ? 1'b1 : (cl ? 1'b0 : m_flag);
        case (m_mode)
            0: begin m_cnt = 0; if (sl != 0) m_mode = 1; end
            1: begin
                if (sl == 0)      begin m_mode = 0; m_cnt = 0; end
                else if (to)      begin m_mode = 2; m_pls = 0; m_cnt = 0; end
                else if (sv)      m_cnt = 0;
                else if (tk)      m_cnt++;
            end
            default: begin
                m_cnt = 0;
                if (m_pls == PULSE - 1) m_mode = (sl == 0) ? 0 : 1;
                else m_pls++;
            end
        endcase
    endtask

    task automatic cyc(string tag, bit s, bit o, bit [1:0] sl, bit sv, bit cl);
        src_sel = s; osc_tick = o; tmo_sel = sl; svc_wr = sv; flag_clr = cl;
        model_step(s, o, sl, sv, cl);
        @(negedge clk);
        chk({tag, " rst_req_n"}, rst_req_n, (m_mode != 2));
        chk({tag, " wdg_flag"}, wdg_flag, m_flag);
    endtask

    task automatic run_to_low(string tag, bit s, bit [1:0] sl, int maxn, output int n);
        n = 0;
        do begin
            cyc(tag, s, 1'b1, sl, 1'b0, 1'b0);
            n++;
        end while (rst_req_n && n < maxn);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        bit any_low;
        bit s, sv, o, cl;
        bit [1:0] sl;
        void'($urandom(32'd4711));
        m_mode = 0; m_cnt = 0; m_div = 0; m_pls = 0; m_selq = 0; m_flag = 0;

        repeat (4) @(negedge clk);
        chk("R1 reset rst_req_n", rst_req_n, 1'b1);
        chk("R1 reset wdg_flag", wdg_flag, 1'b0);
        rst_n = 1'b1;

        // R3: disabled, ticks present, no reset request
        any_low = 0;
        repeat (40) begin
            cyc("R3 idle", 1, 1, 2'b00, 0, 0);
            if (!rst_req_n) any_low = 1;
        end
        chk("R3 off never resets", any_low, 1'b0);

        // R5: short timeout, tick every clock
        run_to_low("R5 timeout", 1, 2'b01, 200, n);
        chk_int("R5 clocks to reset", n, 1 + (1 << LA));

        // R6: pulse width, service ignored while low
        n = 0;
        do begin cyc("R6 pulse", 1, 1, 2'b01, 1, 0); n++; end
        while (!rst_req_n && n < 100);
        chk_int("R6 pulse width", n, PULSE);
        chk("R7 flag after pulse", wdg_flag, 1'b1);
        run_to_low("R6 restart", 1, 2'b01, 200, n);
        chk_int("R6 count restarts from zero", n, 1 << LA);
        repeat (PULSE) cyc("R6 wait", 1, 0, 2'b01, 0, 0);
        chk("R6 released", rst_req_n, 1'b1);

        // R7: clear
        cyc("R7 clear", 1, 0, 2'b01, 0, 1);
        chk("R7 flag cleared", wdg_flag, 1'b0);

        // R4: regular service prevents timeout
        any_low = 0;
        for (int i = 0; i < 600; i++) begin
            cyc("R4 service", 1, 1, 2'b01, (i % 20) == 0, 0);
            if (!rst_req_n) any_low = 1;
        end
        chk("R4 serviced never resets", any_low, 1'b0);

        // R8: disable mid-count then re-enable gives a full timeout
        cyc("R8 run", 1, 1, 2'b01, 1, 0);
        repeat (10) cyc("R8 run", 1, 1, 2'b01, 0, 0);
        any_low = 0;
        repeat (100) begin
            cyc("R8 off", 1, 1, 2'b00, 0, 0);
            if (!rst_req_n) any_low = 1;
        end
        chk("R8 off no reset", any_low, 1'b0);
        run_to_low("R8 reenable", 1, 2'b01, 200, n);
        chk_int("R8 full timeout after reenable", n, 1 + (1 << LA));
        repeat (PULSE) cyc("R8 wait", 1, 0, 2'b01, 0, 0);

        // R2: divider source, switch restarts divider
        cyc("R2 switch", 0, 0, 2'b01, 1, 0);
        run_to_low("R2 divided", 0, 2'b01, 6000, n);
        chk_int("R2 clocks to reset via divider", n + 1, 1 + (1 << LA) * DIV);
        repeat (PULSE) cyc("R2 wait", 0, 0, 2'b01, 0, 1);

        // R4: service and final tick in the same clock
        cyc("R4 prio", 1, 0, 2'b01, 1, 0);
        repeat ((1 << LA) - 1) cyc("R4 prio", 1, 1, 2'b01, 0, 0);
        cyc("R4 prio", 1, 1, 2'b01, 1, 0);
        chk("R4 service beats timeout", rst_req_n, 1'b1);
        cyc("R7 set", 1, 0, 2'b00, 0, 1);

        // random mix, all requirements against the model (R2 R3 R4 R5 R6 R7 R8)
        s = 1; sl = 2'b01;
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 499) == 0) s = ~s;
            if ($urandom_range(0, 2999) == 0) sl = 2'($urandom_range(0, 3));
            o  = ($urandom_range(0, 3) == 0);
            sv = ($urandom_range(0, 59) == 0);
            cl = ($urandom_range(0, 399) == 0);
            cyc("R5 random", s, o, sl, sv, cl);
        end

        summary();
        $finish;
    end
endmodule